// File: doc/BRIEF.md
# Interrupt Entry and Vector Sequencer

This block sits next to a small 8-bit CPU core and runs the memory traffic of interrupt entry and return. It watches the count of a down-counting 8-bit timer and latches a timer request when that count steps from one to zero. It gates the request with the timer's own mask and with the global interrupt mask held in the core's condition code register. A software-interrupt request from the core's decoder bypasses the global mask.

When an interrupt is accepted, the block copies the core's registers. It writes five bytes down the stack through a byte-wide write port and sets the global mask in the condition code it returns. It then fetches a two-byte service address through a byte-wide read port. For a return, it reads the same five bytes back up the stack.

Every sequence ends with a one-cycle `ld` pulse. During that pulse the core copies the program counter, index, accumulator, condition code and stack pointer from the block's outputs. The request inputs `swi_req` and `rti_req` are levels that the core holds until it sees `ld`.

Top module: `irq_seq`

## Requirements
- R1: Out of reset `tmr_pend` is 0, and it becomes 1 only in the cycle after `tmr_count` goes from 0x01 to 0x00. Any other change of the count (for example 0x05 to 0x00, or 0x00 held) sets nothing.
- R2: Once set, `tmr_pend` stays 1 until a cycle with `tmr_clr` high, including after its interrupt has been taken. A set that is refused while masked is therefore taken later.
- R3: A pending timer request starts an entry only while `tmr_mask` is 0 and the global mask bit (bit 3 of `ccr_in`) is 0. Otherwise `busy` stays 0.
- R4: On entry the block writes, one byte per cycle with `mem_we` high, starting at address `sp_in` and going down by one each time: PC low byte, PC high byte (upper bits zero), X, A, CCR. `sp_out` is `sp_in` minus 5.
- R5: The CCR byte written on entry is `ccr_in` unchanged. The `ccr_out` given with `ld` equals `ccr_in` with bit 3 set, and `x_out` and `a_out` are unchanged.
- R6: A timer entry outside wait mode loads the program counter from the vector pair at 0x1FF8/0x1FF9.
- R7: A timer entry accepted while `cpu_wait` is 1 uses the pair at 0x1FF6/0x1FF7. `wait_exit` pulses for one cycle, in the cycle that reads 0x1FF6.
- R8: `swi_req` starts an entry whatever bit 3 of `ccr_in` holds, and uses the pair at 0x1FFC/0x1FFD.
- R9: When an enabled timer request and `swi_req` are both present, the timer entry runs first and the software entry follows it.
- R10: The lower-addressed vector byte is read first and supplies bits 12:8 of `pc_out`, with its upper three bits dropped. The higher-addressed byte supplies bits 7:0.
- R11: On `rti_req` the block reads addresses `sp_in`+1 to `sp_in`+5 as CCR, A, X, PC high, PC low, restores all of them (including bit 3 of the CCR), and gives `sp_out` = `sp_in`+5.
- R12: The read port is synchronous: `mem_rdata` is taken one cycle after the cycle that drives `mem_re` and `mem_addr`. `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 8 | Current timer count |
| tmr_mask | input | 1 | Timer interrupt mask, 1 blocks the timer |
| tmr_clr | input | 1 | Clears the latched timer request |
| cpu_wait | input | 1 | Core is in wait mode |
| swi_req | input | 1 | Software-interrupt request level |
| rti_req | input | 1 | Return-from-interrupt request level |
| pc_in | input | 13 | Core program counter |
| x_in | input | 8 | Core index register |
| a_in | input | 8 | Core accumulator |
| ccr_in | input | 8 | Core condition code register, bit 3 = global mask |
| sp_in | input | 13 | Core stack pointer |
| mem_addr | output | 13 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | A sequence is in progress |
| tmr_pend | output | 1 | Latched timer request |
| wait_exit | output | 1 | Pulse: wait mode ends |
| ld | output | 1 | Pulse: load the values below into the core |
| pc_out | output | 13 | New program counter |
| x_out | output | 8 | New index register |
| a_out | output | 8 | New accumulator |
| ccr_out | output | 8 | New condition code register |
| sp_out | output | 13 | New stack pointer |

## Verification
The bench builds the block with its defaults: a 13-bit address and the three vector pairs in the top page. With those values the dropped upper bits of the high vector byte can be observed. The memory model is 256 bytes indexed by the low address byte, which holds both the vectors and the stack region below them. Because the model is an ordinary synchronous memory, the round trip of an entry followed by a return can be checked byte for byte.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VREAD, S_POP, S_DONE} seq_state_e;
    typedef enum logic [1:0] {K_TMR, K_TMR_WAIT, K_SWI, K_RTI} irq_kind_e;
    localparam int unsigned I_BIT    = 3;
    localparam int unsigned PUSH_N   = 5;
    localparam int unsigned STEP_W   = 3;
endpackage

// File: rtl/irq_tmr_latch.sv
module irq_tmr_latch #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             clr,
    output logic             pend
);
    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic             pend;
    } lat_t;

    lat_t lat_d, lat_q;
    logic hit;

    always_comb begin
        lat_d      = lat_q;
        lat_d.prev = count;
        hit        = (lat_q.prev == CNT_W'(1)) && (count == '0);
        if (hit)
            lat_d.pend = 1'b1;
        else if (clr)
            lat_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign pend = lat_q.pend;

    // R1: a new request only follows a one-to-zero step of the count
    p_set_on_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ($past(lat_q.prev) == CNT_W'(1) && $past(count) == '0));
    // R2: the request holds until cleared
    p_hold_until_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned          ADDR_W       = 13,
    parameter logic [ADDR_W-1:0]    VEC_TMR      = 13'h1FF8,
    parameter logic [ADDR_W-1:0]    VEC_TMR_WAIT = 13'h1FF6,
    parameter logic [ADDR_W-1:0]    VEC_SWI      = 13'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        tmr_count,
    input  logic              tmr_mask,
    input  logic              tmr_clr,
    input  logic              cpu_wait,
    input  logic              swi_req,
    input  logic              rti_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [7:0]        x_in,
    input  logic [7:0]        a_in,
    input  logic [7:0]        ccr_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              tmr_pend,
    output logic              wait_exit,
    output logic              ld,
    output logic [ADDR_W-1:0] pc_out,
    output logic [7:0]        x_out,
    output logic [7:0]        a_out,
    output logic [7:0]        ccr_out,
    output logic [ADDR_W-1:0] sp_out
);
    localparam int unsigned HI_W     = ADDR_W - 8;
    localparam logic [STEP_W-1:0] LAST_PUSH = STEP_W'(PUSH_N - 1);
    localparam logic [STEP_W-1:0] LAST_POP  = STEP_W'(PUSH_N);

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        irq_kind_e         kind;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] pc;
        logic [7:0]        x;
        logic [7:0]        a;
        logic [7:0]        ccr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic hw_ok;
    logic [ADDR_W-1:0] vbase;

    irq_tmr_latch #(.CNT_W(8)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tmr_count),
        .clr   (tmr_clr),
        .pend  (tmr_pend)
    );

    always_comb begin
        case (seq_q.kind)
            K_TMR_WAIT: vbase = VEC_TMR_WAIT;
            K_SWI:      vbase = VEC_SWI;
            default:    vbase = VEC_TMR;
        endcase
    end

    always_comb begin
        seq_d     = seq_q;
        mem_addr  = seq_q.sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        wait_exit = 1'b0;
        ld        = 1'b0;
        hw_ok     = tmr_pend && !tmr_mask && !ccr_in[I_BIT];
        case (seq_q.state)
            S_IDLE: begin
                seq_d.step = '0;
                seq_d.sp   = sp_in;
                seq_d.pc   = pc_in;
                seq_d.x    = x_in;
                seq_d.a    = a_in;
                seq_d.ccr  = ccr_in;
                if (hw_ok) begin
                    seq_d.state = S_PUSH;
                    seq_d.kind  = cpu_wait ? K_TMR_WAIT : K_TMR;
                end else if (swi_req) begin
                    seq_d.state = S_PUSH;
                    seq_d.kind  = K_SWI;
                end else if (rti_req) begin
                    seq_d.state = S_POP;
                    seq_d.kind  = K_RTI;
                end
            end
            S_PUSH: begin
                mem_we   = 1'b1;
                mem_addr = seq_q.sp;
                case (seq_q.step)
                    3'd0:    mem_wdata = seq_q.pc[7:0];
                    3'd1:    mem_wdata = 8'(seq_q.pc >> 8);
                    3'd2:    mem_wdata = seq_q.x;
                    3'd3:    mem_wdata = seq_q.a;
                    default: mem_wdata = seq_q.ccr;
                endcase
                seq_d.sp = seq_q.sp - 1'b1;
                if (seq_q.step == LAST_PUSH) begin
                    seq_d.state          = S_VREAD;
                    seq_d.step           = '0;
                    seq_d.ccr[I_BIT]     = 1'b1;
                end else begin
                    seq_d.step = seq_q.step + 1'b1;
                end
            end
            S_VREAD: begin
                case (seq_q.step)
                    3'd0: begin
                        mem_re     = 1'b1;
                        mem_addr   = vbase;
                        wait_exit  = (seq_q.kind == K_TMR_WAIT);
                        seq_d.step = 3'd1;
                    end
                    3'd1: begin
                        mem_re     = 1'b1;
                        mem_addr   = vbase + 1'b1;
                        seq_d.pc   = {mem_rdata[HI_W-1:0], seq_q.pc[7:0]};
                        seq_d.step = 3'd2;
                    end
                    default: begin
                        seq_d.pc[7:0] = mem_rdata;
                        seq_d.state   = S_DONE;
                    end
                endcase
            end
            S_POP: begin
                if (seq_q.step != LAST_POP) begin
                    mem_re   = 1'b1;
                    mem_addr = seq_q.sp + 1'b1;
                    seq_d.sp = seq_q.sp + 1'b1;
                end
                case (seq_q.step)
                    3'd1: seq_d.ccr = mem_rdata;
                    3'd2: seq_d.a   = mem_rdata;
                    3'd3: seq_d.x   = mem_rdata;
                    3'd4: seq_d.pc  = {mem_rdata[HI_W-1:0], seq_q.pc[7:0]};
                    3'd5: seq_d.pc[7:0] = mem_rdata;
                    default: ;
                endcase
                if (seq_q.step == LAST_POP) seq_d.state = S_DONE;
                else                        seq_d.step  = seq_q.step + 1'b1;
            end
            default: begin
                ld          = 1'b1;
                seq_d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= S_IDLE;
            seq_q.kind  <= K_TMR;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.state != S_IDLE);
    assign pc_out  = seq_q.pc;
    assign x_out   = seq_q.x;
    assign a_out   = seq_q.a;
    assign ccr_out = seq_q.ccr;
    assign sp_out  = seq_q.sp;

    // R3: a timer entry starts only from an unmasked pending request
    p_timer_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == S_PUSH && seq_q.step == '0 &&
         (seq_q.kind == K_TMR || seq_q.kind == K_TMR_WAIT))
        |-> $past(tmr_pend && !tmr_mask && !ccr_in[I_BIT]));
    // R4: consecutive stack writes walk down by one
    p_push_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) - 1'b1)));
    // R5: every entry hands back a masked condition code
    p_entry_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && seq_q.kind != K_RTI) |-> ccr_out[I_BIT]);
    // R7: wait exit coincides with the first wait-vector read
    p_wait_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_exit |-> (mem_re && mem_addr == VEC_TMR_WAIT));
    // R11: consecutive stack reads walk up by one
    p_pop_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re) && seq_q.state == S_POP)
        |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
    // R12: the port never reads and writes in one cycle
    p_port_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
endmodule

// File: tb/sim_irq_seq.sv
`timescale 1ns/1ps
module sim_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tmr_count = 8'd9;
    logic        tmr_mask = 1'b0, tmr_clr = 1'b0, cpu_wait = 1'b0;
    logic        swi_req = 1'b0, rti_req = 1'b0;
    logic [12:0] c_pc = '0, c_sp = '0;
    logic [7:0]  c_x = '0, c_a = '0, c_ccr = 8'h08;
    logic [12:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata, x_out, a_out, ccr_out;
    logic        mem_we, mem_re, busy, tmr_pend, wait_exit, ld;

    logic [7:0]  mem [0:255];
    logic [7:0]  rd_q = '0;
    int          nchk = 0, nfail = 0;
    int          wn = 0;
    logic [12:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];
    logic        wx_seen = 1'b0;
    logic [12:0] wx_addr = '0;

    always #4 clk = ~clk;

    irq_seq u0 (
        .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .tmr_mask(tmr_mask),
        .tmr_clr(tmr_clr), .cpu_wait(cpu_wait), .swi_req(swi_req), .rti_req(rti_req),
        .pc_in(c_pc), .x_in(c_x), .a_in(c_a), .ccr_in(c_ccr), .sp_in(c_sp),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .tmr_pend(tmr_pend), .wait_exit(wait_exit),
        .ld(ld), .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .ccr_out(ccr_out),
        .sp_out(sp_out)
    );

    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) rd_q <= mem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if (mem_we && wn < 16) begin
            wlog_a[wn] = mem_addr;
            wlog_d[wn] = mem_wdata;
            wn = wn + 1;
        end
        if (wait_exit) begin
            wx_seen = 1'b1;
            wx_addr = mem_addr;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // waits for the load pulse, then the core model takes the outputs
    task automatic wait_ld(input string req);
        bit got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (ld) got = 1;
        end
        check({req, " ld pulse"}, got, 1);
        c_pc = pc_out; c_x = x_out; c_a = a_out; c_ccr = ccr_out; c_sp = sp_out;
    endtask

    task automatic make_pend();
        @(negedge clk) tmr_count = 8'd2;
        @(negedge clk) tmr_count = 8'd1;
        @(negedge clk) tmr_count = 8'd0;
        @(negedge clk);
    endtask

    task automatic clear_pend();
        tmr_clr = 1'b1;
        @(negedge clk) tmr_clr = 1'b0;
        tmr_count = 8'd9;
    endtask

    task automatic t_reset();
        check("R1 reset pend", tmr_pend, 0);
        check("R1 reset busy", busy, 0);
        check("R12 reset port", {mem_we, mem_re, ld}, 0);
    endtask

    task automatic t_edge();
        c_ccr = 8'h08;
        @(negedge clk) tmr_count = 8'd5;
        @(negedge clk) tmr_count = 8'd0;
        @(negedge clk);
        @(negedge clk);
        check("R1 5->0 sets nothing", tmr_pend, 0);
        make_pend();
        check("R1 1->0 sets pend", tmr_pend, 1);
        repeat (4) @(negedge clk);
        check("R2 held while count stays 0", tmr_pend, 1);
        clear_pend();
        check("R2 clear drops pend", tmr_pend, 0);
        repeat (3) @(negedge clk);
        check("R1 no re-set without new step", tmr_pend, 0);
    endtask

    task automatic t_timer_run();
        c_ccr = 8'h08; tmr_mask = 1'b1;
        make_pend();
        repeat (8) @(negedge clk);
        check("R3 global mask blocks", busy, 0);
        c_ccr = 8'hE0;
        repeat (8) @(negedge clk);
        check("R3 timer mask blocks", busy, 0);
        check("R2 refused request kept", tmr_pend, 1);
        c_pc = 13'h1234; c_x = 8'h11; c_a = 8'h22; c_sp = 13'h00EF;
        wn = 0; wx_seen = 1'b0;
        tmr_mask = 1'b0;
        wait_ld("R6");
        check("R6 run-mode vector", c_pc, 13'h1A34);
        check("R4 write count", wn, 5);
        check("R4 byte0 addr", wlog_a[0], 13'h0EF);
        check("R4 PCL", wlog_d[0], 8'h34);
        check("R4 PCH", wlog_d[1], 8'h12);
        check("R4 X", wlog_d[2], 8'h11);
        check("R4 A", wlog_d[3], 8'h22);
        check("R4 last addr", wlog_a[4], 13'h0EB);
        check("R5 pushed CCR unchanged", wlog_d[4], 8'hE0);
        check("R5 ccr_out mask set", c_ccr, 8'hE8);
        check("R5 x a kept", {c_x, c_a}, 16'h1122);
        check("R4 sp_out", c_sp, 13'h0EA);
        check("R7 no wait exit in run mode", wx_seen, 0);
        @(negedge clk);
        check("R2 pend survives entry", tmr_pend, 1);
        repeat (4) @(negedge clk);
        check("R3 masked after entry", busy, 0);
        clear_pend();
    endtask

    task automatic t_rti();
        // return to the context pushed by the timer entry
        c_sp = 13'h0EA;
        rti_req = 1'b1;
        wait_ld("R11");
        rti_req = 1'b0;
        check("R11 pc restored", c_pc, 13'h1234);
        check("R11 x a restored", {c_x, c_a}, 16'h1122);
        check("R11 ccr mask restored", c_ccr, 8'hE0);
        check("R11 sp_out", c_sp, 13'h0EF);
        // preloaded frame
        mem[8'hD1] = 8'h0A; mem[8'hD2] = 8'h77; mem[8'hD3] = 8'h88;
        mem[8'hD4] = 8'hEB; mem[8'hD5] = 8'hCD;
        c_sp = 13'h0D0;
        @(negedge clk) rti_req = 1'b1;
        wait_ld("R11");
        rti_req = 1'b0;
        check("R11 frame pc, upper bits dropped", c_pc, 13'h0BCD);
        check("R11 frame ccr", c_ccr, 8'h0A);
        check("R11 frame x a", {c_x, c_a}, 16'h8877);
        check("R11 frame sp", c_sp, 13'h0D5);
    endtask

    task automatic t_wait();
        c_ccr = 8'h00; c_sp = 13'h0E0; cpu_wait = 1'b1;
        tmr_mask = 1'b1;
        make_pend();
        wx_seen = 1'b0;
        tmr_mask = 1'b0;
        wait_ld("R7");
        cpu_wait = 1'b0;
        check("R7 wait vector", c_pc, 13'h0566);
        check("R7 wait exit seen", wx_seen, 1);
        check("R7 wait exit address", wx_addr, 13'h1FF6);
        clear_pend();
    endtask

    task automatic t_swi();
        c_ccr = 8'h0C; c_sp = 13'h0E0;
        @(negedge clk) swi_req = 1'b1;
        wait_ld("R8");
        swi_req = 1'b0;
        check("R8 swi under mask, vector", c_pc, 13'h139C);
        check("R10 high byte upper bits dropped", c_pc[12:8], 5'h13);
        check("R5 swi ccr", c_ccr, 8'h0C);
        repeat (3) @(negedge clk);
        check("R8 single entry", busy, 0);
    endtask

    task automatic t_prio();
        c_ccr = 8'h00; c_sp = 13'h0E0; tmr_mask = 1'b1;
        make_pend();
        tmr_mask = 1'b0; swi_req = 1'b1;
        wait_ld("R9");
        check("R9 timer first", c_pc, 13'h1A34);
        wait_ld("R9");
        swi_req = 1'b0;
        check("R9 swi second", c_pc, 13'h139C);
        check("R9 swi frame below timer frame", c_sp, 13'h0D6);
        clear_pend();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'hF6] = 8'h05; mem[8'hF7] = 8'h66;
        mem[8'hF8] = 8'h1A; mem[8'hF9] = 8'h34;
        mem[8'hFC] = 8'hF3; mem[8'hFD] = 8'h9C;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_edge();
        t_timer_run();
        t_rti();
        t_wait();
        t_swi();
        t_prio();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail = nfail + 1;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule